// File: doc/BRIEF.md
# Demultiplexing Registered Bus Transceiver

This block fans one narrow input word out to several equally wide output groups. Each group keeps its own copy of the word in a storage element. That element acts as a transparent latch while the group's latch enable is high. Once the latch enable is low, it becomes an edge-triggered register. A single active-low clock enable is shared by all groups. A binary select steers that enable to exactly one group, so a host can deposit successive words into successive groups, one clock at a time, while the other groups hold.

Each group has an output gate that is the product of a global active-low output enable and the group's own active-low output enable. The high-impedance state of a real bus driver is modelled as a per-group drive flag. When the flag is low, the group's data lines read as zero. Everything runs in one clock domain. The latch behaviour is a combinational bypass around a register that keeps loading while the latch enable is high.

Top module: `demux_xcvr`

## Requirements
- R1: All four groups take their data from the same input word `a_in`. Group g occupies bits [4g+3:4g] of `grp_data`.
- R2: While `grp_le[g]` is high, group g's data equals `a_in` in the same cycle, whatever the clock enable and select.
- R3: After `grp_le[g]` goes from high to low, group g holds the value `a_in` had at the last rising clock edge at which `grp_le[g]` was high.
- R4: With `grp_le[g]` low, group g loads `a_in` on a rising clock edge only when `clken_n` is 0 and `ce_sel` equals g. The encoding is 00 for group 0, 01 for group 1, 10 for group 2 and 11 for group 3.
- R5: A group whose latch enable is low and which is not selected keeps its stored value across clock edges.
- R6: While `clken_n` is 1, no group with a low latch enable changes its value; groups with a high latch enable still follow `a_in`.
- R7: `grp_drive[g]` is 1 exactly when `oe_all_n` and `grp_oe_n[g]` are both 0. When `grp_drive[g]` is 0, group g's data bits read as 0.
- R8: Driving `rst_n` low clears all stored values to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 4 | Shared input word |
| clken_n | input | 1 | Active-low shared clock enable |
| ce_sel | input | 2 | Selects which group receives the clock enable |
| grp_le | input | 4 | Per-group latch enables, active high |
| oe_all_n | input | 1 | Global active-low output enable |
| grp_oe_n | input | 4 | Per-group active-low output enables |
| grp_data | output | 16 | Four output groups, group g in bits [4g+3:4g] |
| grp_drive | output | 4 | Per-group drive flag; 0 models high impedance |

## Verification
Stored state is only visible while a group's latch enable is low and its drive flag is high. A corrupted or wrongly steered register therefore shows on the very next sampling point after the faulty edge. The condition is that the bench reads every group with the latch enable low and all outputs enabled. The stimulus loads a different value into each group through the select. It then reads all four groups together, so a wrong decode appears as a repeated or missing value in one slice. Latch capture is checked by dropping the latch enable one cycle after a new word is presented. The gate is checked by disabling alternate groups. The reset check looks at the outputs before any clock edge.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int unsigned DMX_DW = 4;
  localparam int unsigned DMX_NG = 4;
  localparam int unsigned DMX_SW = (DMX_NG > 1) ? $clog2(DMX_NG) : 1;
endpackage

// File: rtl/dmx_steer.sv
module dmx_steer #(
  parameter int unsigned NG = 4,
  parameter int unsigned SW = 2
) (
  input  logic          clken_n,
  input  logic [SW-1:0] sel,
  output logic [NG-1:0] load
);
  for (genvar g = 0; g < NG; g++) begin : g_dec
    assign load[g] = !clken_n && (sel == SW'(g));
  end

  // R4: at most one group is ever steered a load
  always_comb begin
    a_r4_one_load: assert ($onehot0(load));
  end
  // R6: no load pulses while the shared enable is inactive
  always_comb begin
    a_r6_no_load_when_off: assert (!clken_n || load == '0);
  end
endmodule

// File: rtl/dmx_cell.sv
module dmx_cell #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          le,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] q_r, q_nx;
  logic          upd;

  assign upd = le | load;

  always_comb begin
    q_nx = q_r;
    if (upd) q_nx = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nx;
  end

  assign dout = le ? din : q_r;

  // R3: falling latch enable leaves the word from the previous edge
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(le) && !le && !$past(load)) |-> dout == $past(din));
  // R5: an idle, closed cell keeps its value
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !load) |=> (le || dout == $past(dout)));
endmodule

// File: rtl/dmx_gate.sv
module dmx_gate #(
  parameter int unsigned DW = 4,
  parameter int unsigned NG = 4
) (
  input  logic             oe_all_n,
  input  logic [NG-1:0]    oe_n,
  input  logic [NG*DW-1:0] din,
  output logic [NG*DW-1:0] dout,
  output logic [NG-1:0]    drive
);
  for (genvar g = 0; g < NG; g++) begin : g_gate
    assign drive[g]              = !oe_all_n && !oe_n[g];
    assign dout[g*DW +: DW]      = drive[g] ? din[g*DW +: DW] : '0;
  end
endmodule

// File: rtl/demux_xcvr.sv
module demux_xcvr
  import dmx_pkg::*;
#(
  parameter int unsigned DW = DMX_DW,
  parameter int unsigned NG = DMX_NG,
  parameter int unsigned SW = DMX_SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    a_in,
  input  logic             clken_n,
  input  logic [SW-1:0]    ce_sel,
  input  logic [NG-1:0]    grp_le,
  input  logic             oe_all_n,
  input  logic [NG-1:0]    grp_oe_n,
  output logic [NG*DW-1:0] grp_data,
  output logic [NG-1:0]    grp_drive
);
  localparam int unsigned TW = NG * DW;

  logic [NG-1:0] load;
  logic [TW-1:0] cell_q;

  dmx_steer #(.NG(NG), .SW(SW)) u_steer (
    .clken_n (clken_n),
    .sel     (ce_sel),
    .load    (load)
  );

  for (genvar g = 0; g < NG; g++) begin : g_cell
    dmx_cell #(.DW(DW)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .le    (grp_le[g]),
      .load  (load[g]),
      .din   (a_in),
      .dout  (cell_q[g*DW +: DW])
    );

    // R2: an open latch with an enabled output shows the shared word
    a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_le[g] && grp_drive[g]) |-> grp_data[g*DW +: DW] == a_in);
    // R4: a selected, closed group shows the loaded word one edge later
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!grp_le[g] && !clken_n && ce_sel == SW'(g)) |=>
        (grp_le[g] || !grp_drive[g] || grp_data[g*DW +: DW] == $past(a_in)));
  end

  dmx_gate #(.DW(DW), .NG(NG)) u_gate (
    .oe_all_n (oe_all_n),
    .oe_n     (grp_oe_n),
    .din      (cell_q),
    .dout     (grp_data),
    .drive    (grp_drive)
  );

  // R7: a global disable leaves every group undriven and quiet
  a_r7_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_all_n |-> (grp_drive == '0 && grp_data == '0));
endmodule

// File: tb/demux_xcvr_tb.sv
module demux_xcvr_tb;
  localparam int NV = 12;

  logic        clk;
  logic        rst_n;
  logic [3:0]  a_in;
  logic        clken_n;
  logic [1:0]  ce_sel;
  logic [3:0]  grp_le;
  logic        oe_all_n;
  logic [3:0]  grp_oe_n;
  logic [15:0] grp_data;
  logic [3:0]  grp_drive;

  int n_run;
  int n_fail;
  logic [3:0] mq [4];

  demux_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .clken_n(clken_n),
    .ce_sel(ce_sel), .grp_le(grp_le), .oe_all_n(oe_all_n),
    .grp_oe_n(grp_oe_n), .grp_data(grp_data), .grp_drive(grp_drive)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // stimulus: {le[4], clken_n, sel[2], a[4], oe_all_n, oe_n[4]}
  localparam logic [15:0] VEC [NV] = '{
    {4'b1111, 1'b1, 2'b00, 4'h5, 1'b0, 4'b0000}, // R1 R2 all open
    {4'b0000, 1'b1, 2'b00, 4'hA, 1'b0, 4'b0000}, // R3 R6 closed, hold 5
    {4'b0000, 1'b0, 2'b00, 4'h3, 1'b0, 4'b0000}, // R4 load group 0
    {4'b0000, 1'b0, 2'b01, 4'h9, 1'b0, 4'b0000}, // R4 load group 1
    {4'b0000, 1'b0, 2'b10, 4'hC, 1'b0, 4'b0000}, // R4 load group 2
    {4'b0000, 1'b0, 2'b11, 4'h6, 1'b0, 4'b0000}, // R4 load group 3
    {4'b0000, 1'b1, 2'b00, 4'hF, 1'b0, 4'b0000}, // R5 R6 all hold
    {4'b0100, 1'b1, 2'b00, 4'h7, 1'b0, 4'b0000}, // R2 R6 open with ce off
    {4'b0000, 1'b0, 2'b01, 4'h1, 1'b0, 4'b0000}, // R3 R5 group 2 keeps 7
    {4'b0000, 1'b1, 2'b00, 4'h2, 1'b1, 4'b0000}, // R7 global disable
    {4'b0000, 1'b1, 2'b00, 4'h2, 1'b0, 4'b1010}, // R7 per-group disable
    {4'b0000, 1'b1, 2'b00, 4'h2, 1'b0, 4'b0000}  // R5 final readback
  };
  localparam string TAG [NV] = '{
    "R1/R2", "R3/R6", "R4", "R4", "R4", "R4",
    "R5/R6", "R2/R6", "R3/R5", "R7", "R7", "R5"
  };

  task automatic apply(input logic [15:0] v);
    {grp_le, clken_n, ce_sel, a_in, oe_all_n, grp_oe_n} = v;
  endtask

  task automatic check(input string tag);
    logic [15:0] ed;
    logic [3:0]  ev;
    for (int g = 0; g < 4; g++) begin
      ev[g] = !oe_all_n && !grp_oe_n[g];
      ed[g*4 +: 4] = ev[g] ? (grp_le[g] ? a_in : mq[g]) : 4'h0;
    end
    n_run++;
    if (grp_data !== ed || grp_drive !== ev) begin
      n_fail++;
      $display("FAIL %s: data %h drive %b, expected data %h drive %b",
               tag, grp_data, grp_drive, ed, ev);
    end
  endtask

  task automatic model_edge();
    for (int g = 0; g < 4; g++) begin
      if (grp_le[g] || (!clken_n && ce_sel == 2'(g))) mq[g] = a_in;
    end
  endtask

  initial begin
    n_run = 0;
    n_fail = 0;
    for (int g = 0; g < 4; g++) mq[g] = 4'h0;
    rst_n = 1'b0;
    apply({4'b0000, 1'b1, 2'b00, 4'h0, 1'b0, 4'b0000});
    repeat (3) @(negedge clk);
    #1 check("R8 reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      #1 check(TAG[i]);
      @(posedge clk);
      model_edge();
    end

    // R2: open latch wins over a load steered to the same group
    @(negedge clk);
    apply({4'b0001, 1'b0, 2'b00, 4'hB, 1'b0, 4'b0000});
    #1 check("R2 open vs load");
    @(posedge clk);
    model_edge();

    // R8: reset clears stored values without a clock edge
    @(negedge clk);
    apply({4'b0000, 1'b1, 2'b00, 4'hE, 1'b0, 4'b0000});
    rst_n = 1'b0;
    for (int g = 0; g < 4; g++) mq[g] = 4'h0;
    #1 check("R8 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R8 after release");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule